// File: doc/BRIEF.md
# Indirect Link Register Bridge

This block lets a host on the core clock reach the link-layer registers of a serial storage port (status, error, control, active and notification) that live behind a slow, latency-bound crossing. The host never touches those registers directly. It sees a small window of four words: a data word, a read-launch address word, a write-launch address word and a control/status word.

To read a link register the host writes the register's byte address into the read-launch word, polls the done bit in the control word, and then takes the value from the data word. To write, the host first loads the data word and then writes the byte address into the write-launch word. That write carries the loaded value across and raises the done bit once it has landed. The byte address of link register `n` is `0x20 + 4*n`.

The far side is modelled as a register file reached through fixed-latency request and response delay lines. This reproduces the round-trip timing of the real crossing.

Top module: `lnk_sc_bridge`

## Requirements
- R1: After reset the data word (offset 28), both launch-address words (offsets 29 and 30) and the control word (offset 31) read 0. The remote control, active, notification and error registers also hold 0.
- R2: A host write to offset 29 (read launch) or offset 30 (write launch) while idle starts a transaction. From the next cycle the control word reads busy (bit 1) = 1 and done (bit 0) = 0.
- R3: A transaction started on clock edge t completes on edge t + 2*LAT. From then on the control word reads busy = 0 and done = 1. For a read, the data word then holds the remote register value sampled on edge t + LAT.
- R4: A write launch sends the data word as it was before the launch edge to the addressed register. The data word keeps its value when the write completes.
- R5: The remote byte address selects register index (addr - 0x20)/4 for the aligned 32-bit addresses 0x20 to 0x30. Any other address reads as 0 and its write changes nothing, yet the transaction still completes with done = 1.
- R6: Remote index 0 (status) reads as the 4-bit link_state input in bits 3:0 with all upper bits 0. A value of 3 there means a device is present and the PHY is ready. Writes to it are ignored.
- R7: Remote index 1 (error) is write-one-to-clear. Each bit set in err_set in a cycle sets that bit. When a set and a clear of the same bit fall on the same edge, the set wins.
- R8: Remote indices 2, 3 and 4 are plain 32-bit read/write registers.
- R9: While a transaction is in flight, host writes to any offset are ignored. This covers the data word and both launch words, so no second transaction starts.
- R10: Host writes to the control word, or to any offset other than 28 to 31, have no effect. Reads of offsets 0 to 27 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for one cycle |
| host_addr | input | 5 | Host word offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr (combinational) |
| link_state | input | 4 | Link detection state shown in remote status bits 3:0 |
| err_set | input | 32 | Per-bit error events from the link |

## Verification
Two functions can meet on one clock edge: the link raising an error bit through err_set, and a host write-one-to-clear of the error register arriving at the far side. The bench provokes this by pulsing err_set on exactly the edge where a launched error write lands, LAT edges after its start. It then reads the register back and expects the colliding bit to remain set while the other written ones are cleared. A second meeting point is a host write that arrives in the same cycle a transaction completes. The bench fires writes throughout the busy window and compares every word against its behavioural model on each clock.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    localparam int DW   = 32;
    localparam int HAW  = 5;
    localparam int LSW  = 4;
    localparam int NREG = 5;
    localparam int IDXW = 3;

    localparam logic [HAW-1:0] WO_DATA  = 5'd28;
    localparam logic [HAW-1:0] WO_RADDR = 5'd29;
    localparam logic [HAW-1:0] WO_WADDR = 5'd30;
    localparam logic [HAW-1:0] WO_CTRL  = 5'd31;

    localparam logic [DW-1:0] RBASE = 32'h20;
    localparam logic [DW-1:0] RLAST = RBASE + DW'(4 * (NREG - 1));

    typedef enum logic [IDXW-1:0] {
        RI_STAT = 3'd0,
        RI_ERR  = 3'd1,
        RI_CTRL = 3'd2,
        RI_ACT  = 3'd3,
        RI_NOTE = 3'd4
    } rix_e;

    typedef struct packed {
        logic          wr;
        logic [DW-1:0] baddr;
        logic [DW-1:0] data;
    } req_t;

    typedef struct packed {
        logic hit;
        rix_e idx;
    } dec_t;

    function automatic dec_t addr_decode(input logic [DW-1:0] a);
        dec_t          r;
        logic [DW-1:0] off;
        off   = a - RBASE;
        r.hit = (a >= RBASE) && (a <= RLAST) && (a[1:0] == 2'b00);
        r.idx = rix_e'(off[IDXW+1:2]);
        return r;
    endfunction

endpackage

// File: rtl/lnk_delay.sv
module lnk_delay #(
    parameter int W   = 8,
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_v,
    input  logic [W-1:0] in_d,
    output logic         out_v,
    output logic [W-1:0] out_d
);
    generate
        if (LAT == 0) begin : g_wire
            assign out_v = in_v;
            assign out_d = in_d;
        end else begin : g_pipe
            logic [LAT-1:0] v_q;
            logic [W-1:0]   d_q [LAT];

            always_ff @(posedge clk) begin
                if (rst) v_q[0] <= 1'b0;
                else     v_q[0] <= in_v;
                d_q[0] <= in_d;
            end

            for (genvar s = 1; s < LAT; s++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst) v_q[s] <= 1'b0;
                    else     v_q[s] <= v_q[s-1];
                    d_q[s] <= d_q[s-1];
                end
            end

            assign out_v = v_q[LAT-1];
            assign out_d = d_q[LAT-1];
        end
    endgenerate
endmodule

// File: rtl/lnk_host_side.sv
module lnk_host_side
    import lnk_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           host_wr,
    input  logic [HAW-1:0] host_addr,
    input  logic [DW-1:0]  host_wdata,
    output logic [DW-1:0]  host_rdata,
    output logic           start_o,
    output req_t           req_o,
    input  logic           rsp_v_i,
    input  logic [DW-1:0]  rsp_d_i,
    output logic           busy_o,
    output logic           done_o
);
    logic [DW-1:0] data_q, raddr_q, waddr_q;
    logic          busy_q, done_q, op_wr_q;
    logic          accept, go_rd, go_wr;

    assign accept = host_wr && !busy_q;
    assign go_rd  = accept && (host_addr == WO_RADDR);
    assign go_wr  = accept && (host_addr == WO_WADDR);

    assign start_o  = go_rd || go_wr;
    assign req_o.wr    = go_wr;
    assign req_o.baddr = host_wdata;
    assign req_o.data  = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            raddr_q <= '0;
            waddr_q <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            op_wr_q <= 1'b0;
        end else begin
            if (rsp_v_i) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                if (!op_wr_q) data_q <= rsp_d_i;
            end
            if (accept) begin
                case (host_addr)
                    WO_DATA:  data_q <= host_wdata;
                    WO_RADDR: begin
                        raddr_q <= host_wdata;
                        busy_q  <= 1'b1;
                        done_q  <= 1'b0;
                        op_wr_q <= 1'b0;
                    end
                    WO_WADDR: begin
                        waddr_q <= host_wdata;
                        busy_q  <= 1'b1;
                        done_q  <= 1'b0;
                        op_wr_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (host_addr)
            WO_DATA:  host_rdata = data_q;
            WO_RADDR: host_rdata = raddr_q;
            WO_WADDR: host_rdata = waddr_q;
            WO_CTRL:  host_rdata = {{(DW-2){1'b0}}, busy_q, done_q};
            default:  host_rdata = '0;
        endcase
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
endmodule

// File: rtl/lnk_remote_file.sv
module lnk_remote_file
    import lnk_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           req_v,
    input  req_t           req,
    input  logic [LSW-1:0] link_state,
    input  logic [DW-1:0]  err_set,
    output logic           rsp_v,
    output logic [DW-1:0]  rsp_d
);
    logic [DW-1:0] err_q, ctrl_q, act_q, note_q;
    logic [DW-1:0] err_clr;
    dec_t          dec;
    logic          wr_hit;

    assign dec    = addr_decode(req.baddr);
    assign wr_hit = req_v && req.wr && dec.hit;

    always_comb begin
        err_clr = '0;
        if (wr_hit && dec.idx == RI_ERR) err_clr = req.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q  <= '0;
            ctrl_q <= '0;
            act_q  <= '0;
            note_q <= '0;
        end else begin
            err_q <= (err_q & ~err_clr) | err_set;
            if (wr_hit) begin
                case (dec.idx)
                    RI_CTRL: ctrl_q <= req.data;
                    RI_ACT:  act_q  <= req.data;
                    RI_NOTE: note_q <= req.data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rsp_d = '0;
        if (dec.hit) begin
            case (dec.idx)
                RI_STAT: rsp_d = {{(DW-LSW){1'b0}}, link_state};
                RI_ERR:  rsp_d = err_q;
                RI_CTRL: rsp_d = ctrl_q;
                RI_ACT:  rsp_d = act_q;
                RI_NOTE: rsp_d = note_q;
                default: rsp_d = '0;
            endcase
        end
    end

    assign rsp_v = req_v;
endmodule

// File: rtl/lnk_sc_bridge.sv
module lnk_sc_bridge
    import lnk_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           host_wr,
    input  logic [HAW-1:0] host_addr,
    input  logic [DW-1:0]  host_wdata,
    output logic [DW-1:0]  host_rdata,
    input  logic [LSW-1:0] link_state,
    input  logic [DW-1:0]  err_set
);
    localparam int RQW = $bits(req_t);

    logic          start;
    req_t          req_h, req_r;
    logic [RQW-1:0] req_r_bits;
    logic          rmt_v;
    logic          rmt_rsp_v;
    logic [DW-1:0] rmt_rsp_d;
    logic          rsp_v;
    logic [DW-1:0] rsp_d;
    logic          seq_busy, seq_done;

    lnk_host_side u_host (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .start_o    (start),
        .req_o      (req_h),
        .rsp_v_i    (rsp_v),
        .rsp_d_i    (rsp_d),
        .busy_o     (seq_busy),
        .done_o     (seq_done)
    );

    lnk_delay #(.W(RQW), .LAT(LAT)) u_fwd (
        .clk   (clk),
        .rst   (rst),
        .in_v  (start),
        .in_d  (req_h),
        .out_v (rmt_v),
        .out_d (req_r_bits)
    );

    assign req_r = req_t'(req_r_bits);

    lnk_remote_file u_rmt (
        .clk        (clk),
        .rst        (rst),
        .req_v      (rmt_v),
        .req        (req_r),
        .link_state (link_state),
        .err_set    (err_set),
        .rsp_v      (rmt_rsp_v),
        .rsp_d      (rmt_rsp_d)
    );

    lnk_delay #(.W(DW), .LAT(LAT)) u_bwd (
        .clk   (clk),
        .rst   (rst),
        .in_v  (rmt_rsp_v),
        .in_d  (rmt_rsp_d),
        .out_v (rsp_v),
        .out_d (rsp_d)
    );
endmodule

// File: rtl/lnk_sc_bridge_chk.sv
module lnk_sc_bridge_chk
    import lnk_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           host_wr,
    input logic [HAW-1:0] host_addr,
    input logic           busy,
    input logic           done,
    input logic           rsp_v,
    input logic           rmt_v,
    input logic [DW-1:0]  err_set,
    input logic [DW-1:0]  err_q
);
    // R2
    launch_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !busy && (host_addr == WO_RADDR || host_addr == WO_WADDR))
        |=> (busy && !done));

    // R3
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R3
    finish_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_v |=> (done && !busy));

    // R9
    hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !rsp_v) |=> busy);

    // R9
    remote_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
        rmt_v |-> busy);

    // R7
    err_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (err_set != '0) |=> ((err_q & $past(err_set)) == $past(err_set)));
endmodule

bind lnk_sc_bridge lnk_sc_bridge_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .busy      (seq_busy),
    .done      (seq_done),
    .rsp_v     (rsp_v),
    .rmt_v     (rmt_v),
    .err_set   (err_set),
    .err_q     (u_rmt.err_q)
);

// File: tb/lnk_sc_bridge_bench.sv
module lnk_sc_bridge_bench;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [4:0]  host_addr = 5'd31;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [3:0]  link_state = 4'd0;
    logic [31:0] err_set = '0;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    lnk_sc_bridge #(.LAT(LAT)) u_lnk_sc_bridge (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .link_state (link_state),
        .err_set    (err_set)
    );

    // behavioural reference
    logic [31:0] m_data, m_raddr, m_waddr, m_req_a, m_req_d, m_rsp;
    logic [31:0] m_err, m_ctl, m_act, m_note;
    logic        m_busy, m_done, m_opwr;
    int          m_cnt;

    function automatic logic [31:0] m_remote(input logic [31:0] a);
        case (a)
            32'h20:  return {28'd0, link_state};
            32'h24:  return m_err;
            32'h28:  return m_ctl;
            32'h2C:  return m_act;
            32'h30:  return m_note;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] m_word(input logic [4:0] a);
        case (a)
            5'd28:   return m_data;
            5'd29:   return m_raddr;
            5'd30:   return m_waddr;
            5'd31:   return {30'd0, m_busy, m_done};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string m_tag(input logic [4:0] a);
        case (a)
            5'd28:   return "R3";
            5'd29:   return "R9";
            5'd30:   return "R9";
            5'd31:   return "R2";
            default: return "R10";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_data = 0; m_raddr = 0; m_waddr = 0; m_req_a = 0; m_req_d = 0; m_rsp = 0;
            m_err = 0; m_ctl = 0; m_act = 0; m_note = 0;
            m_busy = 0; m_done = 0; m_opwr = 0; m_cnt = 0;
        end else begin
            logic        was_busy;
            logic [31:0] clr;
            was_busy = m_busy;
            clr = 0;
            if (m_busy) begin
                if (m_cnt == LAT - 1) begin
                    m_rsp = m_remote(m_req_a);
                    if (m_opwr) begin
                        case (m_req_a)
                            32'h24: clr = m_req_d;
                            32'h28: m_ctl = m_req_d;
                            32'h2C: m_act = m_req_d;
                            32'h30: m_note = m_req_d;
                            default: ;
                        endcase
                    end
                end
                if (m_cnt == 2 * LAT - 1) begin
                    m_busy = 0;
                    m_done = 1;
                    if (!m_opwr) m_data = m_rsp;
                end
                m_cnt++;
            end
            m_err = (m_err & ~clr) | err_set;
            if (host_wr && !was_busy) begin
                case (host_addr)
                    5'd28: m_data = host_wdata;
                    5'd29, 5'd30: begin
                        if (host_addr == 5'd29) m_raddr = host_wdata;
                        else                    m_waddr = host_wdata;
                        m_opwr  = (host_addr == 5'd30);
                        m_req_a = host_wdata;
                        m_req_d = m_data;
                        m_busy  = 1;
                        m_done  = 0;
                        m_cnt   = 0;
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, a quarter period after each edge
    always @(posedge clk) begin
        #5;
        if (!rst) check(m_tag(host_addr), host_rdata, m_word(host_addr));
    end

    task automatic hw(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_addr = 5'd31;
    endtask

    task automatic look(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        host_addr = a;
        #1;
        check(tag, host_rdata, exp);
    endtask

    task automatic settle;
        repeat (2 * LAT + 2) @(negedge clk);
    endtask

    task automatic rd_reg(input logic [31:0] ba, input logic [31:0] exp, input string tag);
        hw(5'd29, ba);
        settle();
        look(5'd28, exp, tag);
    endtask

    task automatic wr_reg(input logic [31:0] ba, input logic [31:0] d);
        hw(5'd28, d);
        hw(5'd30, ba);
        settle();
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        look(5'd28, 32'd0, "R1");
        look(5'd29, 32'd0, "R1");
        look(5'd30, 32'd0, "R1");
        look(5'd31, 32'd0, "R1");
        rd_reg(32'h28, 32'd0, "R1");
        rd_reg(32'h24, 32'd0, "R1");

        // R6 status mirrors link_state, writes ignored
        link_state = 4'd3;
        rd_reg(32'h20, 32'd3, "R6");
        wr_reg(32'h20, 32'hFFFF_FFFF);
        link_state = 4'd1;
        rd_reg(32'h20, 32'd1, "R6");

        // R4 / R8 write then read back
        wr_reg(32'h28, 32'hA5A5_0001);
        look(5'd28, 32'hA5A5_0001, "R4");
        look(5'd31, 32'd1, "R3");
        wr_reg(32'h2C, 32'h1234_5678);
        wr_reg(32'h30, 32'h0000_CAFE);
        rd_reg(32'h28, 32'hA5A5_0001, "R8");
        rd_reg(32'h2C, 32'h1234_5678, "R8");
        rd_reg(32'h30, 32'h0000_CAFE, "R8");

        // R7 set, then clear colliding with a new set
        @(negedge clk); err_set = 32'h0000_000F;
        @(negedge clk); err_set = '0;
        rd_reg(32'h24, 32'h0000_000F, "R7");
        hw(5'd28, 32'h0000_0003);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 5'd30; host_wdata = 32'h24;
        @(posedge clk);
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0; host_addr = 5'd31;
        err_set = 32'h0000_0001;
        @(negedge clk);
        err_set = '0;
        settle();
        rd_reg(32'h24, 32'h0000_000D, "R7");
        wr_reg(32'h24, 32'hFFFF_FFFF);
        rd_reg(32'h24, 32'd0, "R7");

        // R5 translation and bad addresses
        wr_reg(32'h2A, 32'hDEAD_BEEF);
        look(5'd31, 32'd1, "R5");
        rd_reg(32'h28, 32'hA5A5_0001, "R5");
        rd_reg(32'h34, 32'd0, "R5");
        rd_reg(32'h1C, 32'd0, "R5");
        rd_reg(32'h128, 32'd0, "R5");
        wr_reg(32'h12C, 32'h5555_5555);
        rd_reg(32'h2C, 32'h1234_5678, "R5");

        // R2 / R3 exact timing
        hw(5'd29, 32'h2C);
        look(5'd31, 32'd2, "R2");
        repeat (3) @(negedge clk);
        look(5'd31, 32'd2, "R3");
        look(5'd31, 32'd1, "R3");
        look(5'd28, 32'h1234_5678, "R3");

        // R9 writes during flight ignored
        hw(5'd29, 32'h30);
        hw(5'd28, 32'h1111_1111);
        hw(5'd29, 32'h28);
        hw(5'd30, 32'h28);
        settle();
        look(5'd28, 32'h0000_CAFE, "R9");
        look(5'd29, 32'h30, "R9");
        look(5'd30, 32'h12C, "R9");
        rd_reg(32'h28, 32'hA5A5_0001, "R9");

        // R10 stray offsets and control-word writes
        hw(5'd5, 32'h7777_7777);
        look(5'd5, 32'd0, "R10");
        look(5'd0, 32'd0, "R10");
        hw(5'd31, 32'h0000_0000);
        look(5'd31, 32'd1, "R10");
        look(5'd28, 32'hA5A5_0001, "R10");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule